// File: doc/BRIEF.md
# Channel Disable Control Serializer

This block turns a set of per-channel tristate flags into serial control lines for external output buffers. Each control line serves one group of output streams. It carries one bit per channel of every stream in that group and repeats once per frame. A bit is 1 when that stream and channel must be driven to high impedance by the external buffer. The lines run ahead of the data frame, so the buffers have time to act before the matching data appears. The bits for channel 0 start a fixed nine bit clocks before the frame boundary. When output advancement is enabled, the lead grows by a programmable 0 to 3 bit clocks.

A three-state machine locks to the frame pulse. In `ST_HUNT` no pulse has been seen yet. In `ST_LOCK` one pulse has been seen and the block is counting one full frame. In `ST_RUN` the control bits are live. The transitions are as follows. *first_pulse* (HUNT to LOCK) fires on any pulse. *lock_confirm* (LOCK to RUN) fires when a pulse arrives exactly one frame after the last one. *lock_restart* (LOCK to LOCK) fires on a pulse that comes too early, and the count starts again. *lock_lost* (LOCK to HUNT) fires when the frame ends with no pulse. In RUN the block stays in RUN. There a pulse realigns the bit counter, and a missing pulse lets the counter keep running. Until RUN is reached, every control line is held at 1.

Top module: `chan_disable_serializer`

## Requirements
- R1: From reset, and in every state other than run, all control lines read 1. Run is entered only after a frame pulse followed by a second pulse exactly FRAME_BITS (= CHANS*STREAMS_PER_LINE) bit clocks later.
- R2: Line k outputs 1 for a stream/channel exactly when `tri_flags_i[(k*STREAMS_PER_LINE+s)*CHANS+ch]` is 1, where s is the stream within the group and ch is the channel, and 0 otherwise.
- R3: Within a frame the bit order is channel-major: frame bit index i = ch*STREAMS_PER_LINE + s, so every stream's channel 0 comes before any channel 1.
- R4: With advancement disabled, the bit of index i is shown at position (i - 9) mod FRAME_BITS. Position p is the p-th bit clock after the frame boundary, counting from 0, so channel 0 of stream 0 starts at position FRAME_BITS-9, which is nine bit clocks before the boundary.
- R5: With `adv_en_i` = 1, the lead is 9 + `adv_amt_i` bit clocks, and bit i is shown at position (i - 9 - adv_amt_i) mod FRAME_BITS.
- R6: With `adv_en_i` = 0, `adv_amt_i` has no effect on the control lines.
- R7: `frame_pulse_i` is high during the bit clock just before position 0. In run, a pulse at any point restarts the frame count, so that the next bit clock is position 0.
- R8: In run, a missing frame pulse does not disturb the output. The position wraps from FRAME_BITS-1 to 0 by itself.
- R9: In lock, if the frame ends with no pulse, the block returns to hunt, and the lines stay 1 until a new lock completes.
- R10: A change of `tri_flags_i` or of the advancement inputs shows on the control lines at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| frame_pulse_i | input | 1 | High for the bit clock before each frame's position 0 |
| adv_en_i | input | 1 | Enables extra output advancement |
| adv_amt_i | input | ADV_W | Extra lead in bit clocks when enabled |
| tri_flags_i | input | LINES*STREAMS_PER_LINE*CHANS | Per stream/channel tristate flags, stream-major |
| ctl_o | output | LINES | Serial disable control lines, one per stream group |

## Verification
The control lines are registered, so each result appears at the rising edge that follows its cause. A frame pulse sampled at an edge makes the next cycle position 0. A flag or advancement change is visible one edge after it is applied. The bit that confirms lock is the first live bit, at position 0 of the second frame. The bench drives every input and samples every output on the falling edge, and it keeps its own position counter, which it advances at each rising edge. In this way each expected value is compared in the exact cycle it is due. The bench computes each expected bit from the channel-major index formula, with the lead set to 9 or 9 plus the amount.

// File: rtl/cds_pkg.sv
package cds_pkg;

    // Frame lock states
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LOCK = 2'd1,
        ST_RUN  = 2'd2
    } cds_state_e;

endpackage

// File: rtl/cds_frame_fsm.sv
module cds_frame_fsm
    import cds_pkg::*;
#(
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse_i,
    output cds_state_e       state_q,
    output cds_state_e       state_d,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    logic at_last;
    assign at_last = (cnt_q == LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        if (frame_pulse_i || at_last) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (frame_pulse_i) begin
                    state_d = ST_LOCK;                 // first_pulse
                end
            end
            ST_LOCK: begin
                if (frame_pulse_i) begin
                    state_d = at_last ? ST_RUN         // lock_confirm
                                      : ST_LOCK;       // lock_restart
                end else if (at_last) begin
                    state_d = ST_HUNT;                 // lock_lost
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

endmodule

// File: rtl/cds_lead_index.sv
module cds_lead_index #(
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = 5,
    parameter int BASE_LEAD  = 9,
    parameter int ADV_W      = 2
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic             adv_en_i,
    input  logic [ADV_W-1:0] adv_amt_i,
    output logic [CNT_W-1:0] idx_o
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] LEAD_C  = SUM_W'(BASE_LEAD);
    localparam logic [SUM_W-1:0] FRAME_C = SUM_W'(FRAME_BITS);

    logic [SUM_W-1:0] extra;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        extra   = adv_en_i ? SUM_W'(adv_amt_i) : '0;
        sum     = {1'b0, pos_i} + LEAD_C + extra;
        wrapped = (sum >= FRAME_C) ? (sum - FRAME_C) : sum;
        idx_o   = wrapped[CNT_W-1:0];
    end

endmodule

// File: rtl/cds_line_mux.sv
module cds_line_mux #(
    parameter int STREAMS_PER_LINE = 2,
    parameter int CHANS            = 16,
    parameter int CNT_W            = 5
) (
    input  logic [STREAMS_PER_LINE*CHANS-1:0] flags_i,
    input  logic [CNT_W-1:0]                  idx_i,
    output logic                              bit_o
);

    localparam int LINE_W = STREAMS_PER_LINE * CHANS;
    localparam int SEL_W  = (LINE_W > 1) ? $clog2(LINE_W) : 1;

    logic [SEL_W-1:0] sel;

    // Frame index is channel-major; flag storage is stream-major
    always_comb begin
        int unsigned pos;
        int unsigned ch;
        int unsigned st;
        pos = 32'(idx_i);
        ch  = pos / STREAMS_PER_LINE;
        st  = pos % STREAMS_PER_LINE;
        sel = SEL_W'(st * CHANS + ch);
    end

    assign bit_o = flags_i[sel];

endmodule

// File: rtl/chan_disable_serializer.sv
module chan_disable_serializer
    import cds_pkg::*;
#(
    parameter int LINES            = 4,
    parameter int STREAMS_PER_LINE = 2,
    parameter int CHANS            = 16,
    parameter int BASE_LEAD        = 9,
    parameter int ADV_W            = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                frame_pulse_i,
    input  logic                                adv_en_i,
    input  logic [ADV_W-1:0]                    adv_amt_i,
    input  logic [LINES*STREAMS_PER_LINE*CHANS-1:0] tri_flags_i,
    output logic [LINES-1:0]                    ctl_o
);

    localparam int FRAME_BITS = STREAMS_PER_LINE * CHANS;
    localparam int CNT_W      = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam int LINE_W     = STREAMS_PER_LINE * CHANS;

    cds_state_e       state_q;
    cds_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] idx;
    logic [LINES-1:0] line_bits;
    logic [LINES-1:0] ctl_q;

    cds_frame_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .state_q       (state_q),
        .state_d       (state_d),
        .cnt_q         (cnt_q),
        .cnt_d         (cnt_d)
    );

    // Index of the bit due at the position that starts at the next edge
    cds_lead_index #(
        .FRAME_BITS (FRAME_BITS),
        .CNT_W      (CNT_W),
        .BASE_LEAD  (BASE_LEAD),
        .ADV_W      (ADV_W)
    ) u_lead (
        .pos_i     (cnt_d),
        .adv_en_i  (adv_en_i),
        .adv_amt_i (adv_amt_i),
        .idx_o     (idx)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_line
        cds_line_mux #(
            .STREAMS_PER_LINE (STREAMS_PER_LINE),
            .CHANS            (CHANS),
            .CNT_W            (CNT_W)
        ) u_mux (
            .flags_i (tri_flags_i[k*LINE_W +: LINE_W]),
            .idx_i   (idx),
            .bit_o   (line_bits[k])
        );
    end

    // Output register: disabled until the lock is confirmed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '1;
        end else if (state_d == ST_RUN) begin
            ctl_q <= line_bits;
        end else begin
            ctl_q <= '1;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/cds_checker.sv
module cds_checker
    import cds_pkg::*;
#(
    parameter int LINES      = 4,
    parameter int FRAME_BITS = 32,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_pulse_i,
    input logic [LINES-1:0] ctl_o,
    input cds_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

    a_r1_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> (ctl_o == {LINES{1'b1}}))
        else $error("R1 lines not all 1 outside run");

    a_r1_no_run_without_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !frame_pulse_i) |=> (state_q != ST_RUN))
        else $error("R1 run entered without pulse");

    a_r1_lock_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && frame_pulse_i && cnt_q == LAST) |=> (state_q == ST_RUN))
        else $error("R1 lock not confirmed");

    a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse_i |=> (cnt_q == '0))
        else $error("R7 pulse did not realign");

    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse_i && cnt_q != LAST) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)))
        else $error("R8 position did not step");

    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_pulse_i && cnt_q == LAST) |=> (cnt_q == '0))
        else $error("R8 position did not wrap");

    a_r9_lock_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !frame_pulse_i && cnt_q == LAST) |=> (state_q == ST_HUNT))
        else $error("R9 lock loss not taken");

endmodule

bind chan_disable_serializer cds_checker #(
    .LINES      (LINES),
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W)
) u_cds_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_pulse_i (frame_pulse_i),
    .ctl_o         (ctl_o),
    .state_q       (state_q),
    .cnt_q         (cnt_q)
);

// File: tb/chan_disable_serializer_bench.sv
`timescale 1ns/1ps
module chan_disable_serializer_bench;

    localparam int LINES = 4;
    localparam int SPL   = 2;
    localparam int CHANS = 16;
    localparam int ADV_W = 2;
    localparam int FB    = SPL * CHANS;
    localparam int FW    = LINES * SPL * CHANS;

    typedef struct packed {
        logic [FW-1:0]    flags;
        logic             adv_en;
        logic [ADV_W-1:0] amt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{128'h0,                                   1'b0, 2'd0},
        '{{FW{1'b1}},                               1'b0, 2'd0},
        '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0, 2'd0},
        '{128'hAAAA_5555_F0F0_0F0F_CC33_33CC_9696_6969, 1'b1, 2'd3},
        '{128'h8000_0001_0000_FFFF_1234_0000_0000_8001, 1'b1, 2'd1},
        '{128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0, 2'd3}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_pulse_i = 1'b0;
    logic             adv_en_i = 1'b0;
    logic [ADV_W-1:0] adv_amt_i = '0;
    logic [FW-1:0]    tri_flags_i = '0;
    logic [LINES-1:0] ctl_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  pos      = 0;
    bit  pulse_en = 1'b0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    chan_disable_serializer u_chan_disable_serializer (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_pulse_i (frame_pulse_i),
        .adv_en_i      (adv_en_i),
        .adv_amt_i     (adv_amt_i),
        .tri_flags_i   (tri_flags_i),
        .ctl_o         (ctl_o)
    );

    function automatic logic [LINES-1:0] model(input logic [FW-1:0] fl, input int lead, input int p);
        logic [LINES-1:0] r;
        int idx, ch, s;
        idx = (p + lead) % FB;
        ch  = idx / SPL;
        s   = idx % SPL;
        for (int k = 0; k < LINES; k++) r[k] = fl[(k*SPL + s)*CHANS + ch];
        return r;
    endfunction

    function automatic int lead_now();
        return 9 + (adv_en_i ? int'(adv_amt_i) : 0);
    endfunction

    task automatic check(input logic [LINES-1:0] got, input logic [LINES-1:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s pos=%0d got=%b exp=%b", req, pos, got, exp);
        end
    endtask

    // One bit clock: edge, bench position update, falling-edge sample, next pulse
    task automatic cycle(input bit chk, input bit ones, input string req);
        @(posedge clk);
        pos = frame_pulse_i ? 0 : (pos + 1) % FB;
        @(negedge clk);
        if (chk) check(ctl_o, ones ? {LINES{1'b1}} : model(tri_flags_i, lead_now(), pos), req);
        frame_pulse_i = pulse_en && (pos == FB - 1);
    endtask

    task automatic start_lock();
        pulse_en = 1'b1;
        frame_pulse_i = 1'b1;
        pos = FB - 1;
        for (int i = 0; i < FB; i++) cycle(1, 1, "R1");
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(ctl_o, 4'hF, "R1 reset");
        rst_n = 1'b1;
        // No pulse: stays hunting with lines at 1
        for (int i = 0; i < 40; i++) cycle(1, 1, "R1");
        start_lock();

        // Vector table
        for (int v = 0; v < 6; v++) begin
            tri_flags_i = VECS[v].flags;
            adv_en_i    = VECS[v].adv_en;
            adv_amt_i   = VECS[v].amt;
            for (int i = 0; i < 2*FB; i++)
                cycle(1, 0, VECS[v].adv_en ? "R5" : (VECS[v].amt != 0 ? "R6" : "R2"));
        end

        // R4: line 0, stream 0, channel 0 at position FB-9
        tri_flags_i = 128'h1; adv_en_i = 1'b0; adv_amt_i = 2'd3;
        for (int i = 0; i < 2*FB; i++) begin
            cycle(1, 0, "R4");
            if (pos == FB - 10) check(ctl_o, 4'b0000, "R4 before lead");
            if (pos == FB - 9)  check(ctl_o, 4'b0001, "R4 lead 9");
        end
        // R5: lead grows by 3
        adv_en_i = 1'b1;
        for (int i = 0; i < 2*FB; i++) begin
            cycle(1, 0, "R5");
            if (pos == FB - 12) check(ctl_o, 4'b0001, "R5 lead 12");
            if (pos == FB - 9)  check(ctl_o, 4'b0000, "R5 not at 9");
        end
        // R3: line 2 stream 1 channel 0 is frame index 1
        adv_en_i = 1'b0;
        tri_flags_i = '0;
        tri_flags_i[(2*SPL + 1)*CHANS + 0] = 1'b1;
        for (int i = 0; i < 2*FB; i++) begin
            cycle(1, 0, "R3");
            if (pos == FB - 8) check(ctl_o, 4'b0100, "R3 channel-major");
            if (pos == FB - 9) check(ctl_o, 4'b0000, "R3 stream 0 slot");
        end
        // R10: flag change visible at next edge
        tri_flags_i = '0;
        cycle(1, 0, "R10");
        tri_flags_i = {FW{1'b1}};
        cycle(1, 0, "R10");
        check(ctl_o, 4'hF, "R10 next edge");
        // R7: early pulse realigns
        tri_flags_i = VECS[2].flags;
        for (int i = 0; i < 10; i++) cycle(1, 0, "R7");
        frame_pulse_i = 1'b1;
        pos = FB - 1;
        for (int i = 0; i < 2*FB; i++) cycle(1, 0, "R7");
        // R8: missing pulses in run
        pulse_en = 1'b0;
        for (int i = 0; i < 3*FB; i++) cycle(1, 0, "R8");
        pulse_en = 1'b1;
        for (int i = 0; i < FB; i++) cycle(1, 0, "R8");

        // R9: lock lost without second pulse
        rst_n = 1'b0;
        tri_flags_i = '0;
        cycle(0, 1, "R9");
        check(ctl_o, 4'hF, "R1 reset again");
        rst_n = 1'b1;
        frame_pulse_i = 1'b1;
        pos = FB - 1;
        pulse_en = 1'b0;
        for (int i = 0; i < 2*FB; i++) cycle(1, 1, "R9");
        pulse_en = 1'b1;
        for (int i = 0; i < 2*FB; i++) cycle(1, 1, "R9");
        for (int i = 0; i < FB; i++) cycle(1, 0, "R9");
        check(ctl_o, 4'h0, "R9 relocked");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule